// File: doc/BRIEF.md
# Volatile Write-Once Configuration Register Bank

This block keeps a device's configuration bits in volatile flip-flops instead of in the flash array. When power-on reset is released, a small loader fetches two packed 24-bit words from the last two words of program memory through a fixed-latency read port. It spreads their bytes across five 8-bit configuration registers and only then lets the rest of the chip leave reset. A bit that reads 0 counts as programmed and a bit that reads 1 counts as unprogrammed. The loader programs every bit whose flash value is 0, and programming a bit locks it.

After loading, software may program bits through a valid/ready write port that takes a register index, data and a per-bit mask. A masked bit changes only if it has never been written since the last power-on reset, and every write locks the bits it touches. The port holds `wr_ready` low while loading runs and during a warm reset. A requester must keep `wr_valid`, `wr_reg`, `wr_data` and `wr_mask` stable until it sees `wr_ready` high at a rising edge. The write takes effect on that edge. A warm reset holds the system in reset but keeps the stored values and their locks, and it does not start a new load. A combinational read port returns the current value of any register.

Top module: `cfgbank_top`

## Requirements
- R1: After power-on reset the loader requests word 1 and then word 2. `fl_req` is high for one cycle per word. The address pair depends on MEM_SIZE: 0 gives 00ABFEh/00ABFCh, 1 gives 00FFFEh/00FFFCh, and 2 gives 0157FEh/0157FCh. The data is captured RD_LAT+1 cycles after the request cycle.
- R2: `config_ready` stays low for exactly 2*RD_LAT+4 cycles after power-on reset is released, then goes high. `sys_rst_n` is high only when `config_ready` is high and `warm_rst_n` is high.
- R3: Unpacking places bytes as follows. Register 0 takes word 1 bits [7:0] and register 1 takes word 1 bits [15:8]. Register 2 takes word 2 bits [7:0] and register 3 takes word 2 bits [15:8]. Register 4 takes word 1 bits [23:16].
- R4: Bits [23:16] of word 2 have no effect on any register.
- R5: Loading programs and locks exactly the bits whose flash value is 0. Bits loaded as 1 stay writable through the port.
- R6: An accepted write sets each bit selected by `wr_mask` that is still unlocked to the matching `wr_data` bit, and then locks it. Locked bits and unmasked bits keep their value.
- R7: `wr_ready` is low until loading completes. A write held valid across the load is applied exactly once, after `config_ready` rises.
- R8: While `warm_rst_n` is low, `sys_rst_n` and `wr_ready` are low. Values and locks survive the warm reset, and no new load is issued.
- R9: Power-on reset forces every register to all ones and clears every lock. It also starts a fresh load.
- R10: Reads of indices 5 to 7 return all ones, and writes to those indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Any other reset source, active low |
| config_ready | output | 1 | High once both words have been loaded |
| sys_rst_n | output | 1 | Reset release for the rest of the chip |
| fl_req | output | 1 | Program-memory read request |
| fl_addr | output | 24 | Program-memory read address |
| fl_rdata | input | 24 | Program-memory read data, fixed latency |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high together with valid |
| wr_reg | input | 3 | Target register index |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rd_reg | input | 3 | Read register index |
| rd_data | output | 8 | Current value of the selected register |

## Verification
The bench builds the block with MEM_SIZE=1 and RD_LAT=3. The flash model answers only the 00FFFEh/00FFFCh pair, so a wrong address selection shows up as zero data in the registers. The read latency of three makes the wait counter run several steps, which lets the bench check the exact ten-cycle load window and a write stalled across it. The two images in flash contain zeros and ones in every byte, so locked and open bits sit side by side in each register.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned FLAT_W   = NUM_REGS * REG_W;

  typedef enum logic [2:0] {
    LD_REQ1,
    LD_WAIT1,
    LD_REQ2,
    LD_WAIT2,
    LD_DONE
  } ld_state_e;

  // Top-of-memory address of the first (second=0) or second word.
  function automatic logic [WORD_W-1:0] word_addr(input int unsigned size, input logic second);
    logic [WORD_W-1:0] base;
    case (size)
      0:       base = 24'h00ABFE;
      1:       base = 24'h00FFFE;
      default: base = 24'h0157FE;
    endcase
    return second ? (base - 24'd2) : base;
  endfunction
endpackage

// File: rtl/cfgbank_loader.sv
module cfgbank_loader
  import cfgbank_pkg::*;
#(
  parameter int unsigned MEM_SIZE = 2,
  parameter int unsigned RD_LAT   = 2
) (
  input  logic              clk,
  input  logic              por_n,
  output logic              fl_req,
  output logic [WORD_W-1:0] fl_addr,
  input  logic [WORD_W-1:0] fl_rdata,
  output logic              ld_we,
  output logic              ld_second,
  output logic [WORD_W-1:0] ld_word,
  output logic              done
);
  localparam int unsigned CNT_W = $clog2(RD_LAT + 1);
  localparam logic [WORD_W-1:0] ADDR_1 = word_addr(MEM_SIZE, 1'b0);
  localparam logic [WORD_W-1:0] ADDR_2 = word_addr(MEM_SIZE, 1'b1);

  ld_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lat_hit;
  logic             waiting;

  assign lat_hit = (cnt_q == CNT_W'(RD_LAT));
  assign waiting = (st_q == LD_WAIT1) || (st_q == LD_WAIT2);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q  <= LD_REQ1;
      cnt_q <= '0;
    end else begin
      case (st_q)
        LD_REQ1: begin
          st_q  <= LD_WAIT1;
          cnt_q <= '0;
        end
        LD_WAIT1: begin
          if (lat_hit) st_q <= LD_REQ2;
          else         cnt_q <= cnt_q + CNT_W'(1);
        end
        LD_REQ2: begin
          st_q  <= LD_WAIT2;
          cnt_q <= '0;
        end
        LD_WAIT2: begin
          if (lat_hit) st_q <= LD_DONE;
          else         cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= LD_DONE;
      endcase
    end
  end

  assign fl_req    = (st_q == LD_REQ1) || (st_q == LD_REQ2);
  assign fl_addr   = ((st_q == LD_REQ1) || (st_q == LD_WAIT1)) ? ADDR_1 : ADDR_2;
  assign ld_we     = waiting && lat_hit;
  assign ld_second = (st_q == LD_WAIT2);
  assign ld_word   = fl_rdata;
  assign done      = (st_q == LD_DONE);
endmodule

// File: rtl/cfgbank_reg.sv
module cfgbank_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] value,
  output logic [W-1:0] lock
);
  logic [W-1:0] open_bits;

  assign open_bits = we ? (wmask & ~lock) : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      value <= '1;
      lock  <= '0;
    end else begin
      value <= (value & ~open_bits) | (wdata & open_bits);
      lock  <= lock | open_bits;
    end
  end
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int unsigned MEM_SIZE = 2,
  parameter int unsigned RD_LAT   = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  output logic              config_ready,
  output logic              sys_rst_n,
  output logic              fl_req,
  output logic [WORD_W-1:0] fl_addr,
  input  logic [WORD_W-1:0] fl_rdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_reg,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [REG_W-1:0]  wr_mask,
  input  logic [IDX_W-1:0]  rd_reg,
  output logic [REG_W-1:0]  rd_data
);
  logic              ld_we;
  logic              ld_second;
  logic [WORD_W-1:0] ld_word;
  logic              ld_done;
  logic              wr_fire;
  logic [FLAT_W-1:0] val_all;
  logic [FLAT_W-1:0] lock_all;

  cfgbank_loader #(.MEM_SIZE(MEM_SIZE), .RD_LAT(RD_LAT)) u_loader (
    .clk      (clk),
    .por_n    (por_n),
    .fl_req   (fl_req),
    .fl_addr  (fl_addr),
    .fl_rdata (fl_rdata),
    .ld_we    (ld_we),
    .ld_second(ld_second),
    .ld_word  (ld_word),
    .done     (ld_done)
  );

  assign config_ready = ld_done;
  assign wr_ready     = ld_done && warm_rst_n;
  assign sys_rst_n    = ld_done && warm_rst_n;
  assign wr_fire      = wr_valid && wr_ready;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic        FROM_W2  = (g == 2) || (g == 3);
    localparam int unsigned BYTE_SEL = (g == 4) ? 2 : (g % 2);

    logic [REG_W-1:0] ld_byte;
    logic             ld_hit;
    logic             port_hit;
    logic             we;
    logic [REG_W-1:0] wdata;
    logic [REG_W-1:0] wmask;

    assign ld_byte  = ld_word[BYTE_SEL*REG_W +: REG_W];
    assign ld_hit   = ld_we && (ld_second == FROM_W2);
    assign port_hit = wr_fire && (wr_reg == IDX_W'(g));
    assign we       = ld_hit || port_hit;
    // the loader programs the zero bits of the flash byte
    assign wdata    = ld_hit ? ld_byte  : wr_data;
    assign wmask    = ld_hit ? ~ld_byte : wr_mask;

    cfgbank_reg #(.W(REG_W)) u_reg (
      .clk  (clk),
      .por_n(por_n),
      .we   (we),
      .wdata(wdata),
      .wmask(wmask),
      .value(val_all[g*REG_W +: REG_W]),
      .lock (lock_all[g*REG_W +: REG_W])
    );
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_reg == IDX_W'(i)) rd_data = val_all[i*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
  import cfgbank_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              warm_rst_n,
  input logic              config_ready,
  input logic              sys_rst_n,
  input logic              wr_ready,
  input logic              fl_req,
  input logic [FLAT_W-1:0] val_all,
  input logic [FLAT_W-1:0] lock_all
);
  assert_req_while_loading_R1: assert property (@(posedge clk) disable iff (!por_n)
    fl_req |-> !config_ready);

  assert_sysrst_after_load_R2: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_n |-> config_ready);

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (($past(lock_all) & ~lock_all) == '0));

  assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (($past(lock_all) & (val_all ^ $past(val_all))) == '0));

  assert_no_write_while_loading_R7: assert property (@(posedge clk) disable iff (!por_n)
    !config_ready |-> !wr_ready);

  assert_ready_kept_R8: assert property (@(posedge clk) disable iff (!por_n)
    config_ready |=> config_ready);

  assert_warm_holds_R8: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |-> (!sys_rst_n && !wr_ready));
endmodule

bind cfgbank_top cfgbank_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .warm_rst_n  (warm_rst_n),
  .config_ready(config_ready),
  .sys_rst_n   (sys_rst_n),
  .wr_ready    (wr_ready),
  .fl_req      (fl_req),
  .val_all     (val_all),
  .lock_all    (lock_all)
);

// File: tb/sim_cfgbank_top.sv
`timescale 1ns/1ps
module sim_cfgbank_top;
  localparam int unsigned MEM_SIZE = 1;
  localparam int unsigned RD_LAT   = 3;
  localparam logic [23:0] A1 = 24'h00FFFE;
  localparam logic [23:0] A2 = 24'h00FFFC;
  localparam int NVEC = 11;
  // {index, data, mask, expected read-back}
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 8'hFF, 8'h00},
    {3'd0, 8'hFF, 8'hFF, 8'h00},
    {3'd4, 8'h05, 8'h0F, 8'hF0},
    {3'd4, 8'h00, 8'h30, 8'hC0},
    {3'd4, 8'hFF, 8'hF0, 8'hC0},
    {3'd4, 8'h00, 8'hC0, 8'hC0},
    {3'd1, 8'h5A, 8'h00, 8'hA5},
    {3'd1, 8'h00, 8'h01, 8'hA4},
    {3'd3, 8'h3C, 8'hFF, 8'h00},
    {3'd5, 8'h00, 8'hFF, 8'hFF},
    {3'd2, 8'h01, 8'h81, 8'h7E}
  };

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        config_ready, sys_rst_n, fl_req, wr_ready;
  logic [23:0] fl_addr, fl_rdata;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_reg = '0, rd_reg = '0;
  logic [7:0]  wr_data = '0, wr_mask = '0, rd_data;
  logic [23:0] w1_img = 24'hF0A53C;
  logic [23:0] w2_img = 24'h12C37E;
  logic [23:0] pipe [RD_LAT];
  logic [23:0] req_log [8];
  int          n_req = 0;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  cfgbank_top #(.MEM_SIZE(MEM_SIZE), .RD_LAT(RD_LAT)) u0 (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .config_ready(config_ready), .sys_rst_n(sys_rst_n),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_reg(wr_reg),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_reg(rd_reg), .rd_data(rd_data)
  );

  // flash stand-in: address pipeline of RD_LAT stages
  always_ff @(posedge clk) begin
    pipe[0] <= fl_addr;
    for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
  end
  assign fl_rdata = (pipe[RD_LAT-1] == A1) ? w1_img :
                    (pipe[RD_LAT-1] == A2) ? w2_img : 24'h000000;

  always @(negedge clk) begin
    if (por_n && fl_req) begin
      if (n_req < 8) req_log[n_req] = fl_addr;
      n_req++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] idx, input logic [7:0] exp);
    rd_reg = idx;
    #1;
    check(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic do_write(input logic [2:0] idx, input logic [7:0] d, input logic [7:0] m,
                          output int stalls);
    stalls = 0;
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_reg = idx; wr_data = d; wr_mask = m;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
      stalls++;
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic count_load(output int lows);
    lows = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (config_ready) break;
      lows++;
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lows, stalls;
    // reset state (R9)
    repeat (4) @(negedge clk);
    check("R9 ready in POR", {31'h0, config_ready}, 32'h0);
    check("R2 sys_rst_n in POR", {31'h0, sys_rst_n}, 32'h0);
    for (int i = 0; i < 5; i++) rd_chk("R9 ones in POR", 3'(i), 8'hFF);

    @(posedge clk); #1; por_n = 1'b1;
    count_load(lows);
    check("R2 load window", lows, 2*RD_LAT+4);
    check("R2 sys_rst_n released", {31'h0, sys_rst_n}, 32'h1);
    check("R1 request count", n_req, 2);
    check("R1 first address", {8'h0, req_log[0]}, {8'h0, A1});
    check("R1 second address", {8'h0, req_log[1]}, {8'h0, A2});
    rd_chk("R3 reg0", 3'd0, 8'h3C);
    rd_chk("R3 reg1", 3'd1, 8'hA5);
    rd_chk("R3 reg2", 3'd2, 8'h7E);
    rd_chk("R4 reg3 unaffected by word2 upper byte", 3'd3, 8'hC3);
    rd_chk("R3 reg4", 3'd4, 8'hF0);
    rd_chk("R10 index 7 reads ones", 3'd7, 8'hFF);

    // table walk: masked writes against loaded locks
    for (int v = 0; v < NVEC; v++) begin
      do_write(VEC[v][26:24], VEC[v][23:16], VEC[v][15:8], stalls);
      rd_chk("R5/R6/R10 vector", VEC[v][26:24], VEC[v][7:0]);
    end
    rd_chk("R10 reg0 untouched by index 5", 3'd0, 8'h00);

    // warm reset (R8)
    @(posedge clk); #1; warm_rst_n = 1'b0;
    @(negedge clk);
    check("R8 sys_rst_n in warm reset", {31'h0, sys_rst_n}, 32'h0);
    check("R8 wr_ready in warm reset", {31'h0, wr_ready}, 32'h0);
    repeat (3) @(posedge clk);
    #1; warm_rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R8 no reload", n_req, 2);
    check("R8 sys_rst_n back", {31'h0, sys_rst_n}, 32'h1);
    rd_chk("R8 reg0 kept", 3'd0, 8'h00);
    rd_chk("R8 reg4 kept", 3'd4, 8'hC0);
    do_write(3'd4, 8'h00, 8'hC0, stalls);
    rd_chk("R8 locks kept", 3'd4, 8'hC0);

    // second power cycle with new images (R9, R7)
    @(posedge clk); #1; por_n = 1'b0;
    w1_img = 24'hFF00FF;
    w2_img = 24'h00F00F;
    @(negedge clk);
    rd_chk("R9 reg4 forced to ones", 3'd4, 8'hFF);
    check("R9 not ready", {31'h0, config_ready}, 32'h0);
    @(posedge clk); #1; por_n = 1'b1;
    do_write(3'd0, 8'h0F, 8'hFF, stalls);
    check("R7 write stalled during load", {31'h0, stalls > 0}, 32'h1);
    rd_chk("R7 stalled write applied", 3'd0, 8'h0F);
    do_write(3'd0, 8'hF0, 8'hFF, stalls);
    rd_chk("R6 second write ignored", 3'd0, 8'h0F);
    rd_chk("R9 reg1 reloaded", 3'd1, 8'h00);
    rd_chk("R9 reg2 reloaded", 3'd2, 8'h0F);
    rd_chk("R9 reg3 reloaded", 3'd3, 8'hF0);
    rd_chk("R9 reg4 reloaded", 3'd4, 8'hFF);
    check("R9 reload requests", n_req, 4);
    check("R9 reload first address", {8'h0, req_log[2]}, {8'h0, A1});
    check("R9 reload second address", {8'h0, req_log[3]}, {8'h0, A2});
    finish_run();
  end
endmodule